// File: doc/BRIEF.md
# Instruction Parcel Decrypt Stage

This block is one pipeline stage in an instruction fetch path. Code stored in memory may be scrambled with a single machine-wide key. The stage takes a fetch word, splits it into 16-bit parcels and unscrambles every parcel on its own. Each parcel is XORed with a 16-bit mask and then rotated right by a 4-bit amount. Both the mask and the amount come from the same key.

Each fetch comes with a page attribute that says whether the page holding it was stored scrambled. Parcels from unmarked pages pass through untouched, so plain and scrambled programs can run on the same machine. The key sits in a register that only a privileged write can change. The key does not depend on call depth or address.

A fetch is registered once, so results appear one cycle after they are presented. A key change applies only to fetches presented after the write.

Top module: `parcel_decrypt_stage`

## Requirements
- R1: After reset, out_valid and out_word are 0 and the key is all zeros, so a fetch from a marked page comes out unchanged.
- R2: A fetch presented with in_valid high in one cycle appears on out_word, with out_valid high, exactly one clock later. out_valid is never high without a matching fetch.
- R3: For a fetch with in_page_enc high, each parcel is first XORed with key bits [15:0] and then rotated right by key bits [19:16]. Parcel i occupies word bits [16i+15:16i].
- R4: Every parcel of a word is transformed independently with the same key. A parcel's result does not depend on its neighbours.
- R5: For a fetch with in_page_enc low, out_word equals in_word whatever the key.
- R6: A write with key_wr_en and key_wr_priv both high loads key_wr_data into the key. A fetch in the same cycle as the write uses the old key, and fetches from the next cycle on use the new key.
- R7: A write with key_wr_en high and key_wr_priv low is ignored, and the key keeps its value.
- R8: While in_valid is low, out_word holds its last value.
- R9: The stage inverts the scramble (left rotate by key[19:16], then XOR with key[15:0]) for every rotate amount, including 0 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr_en | input | 1 | Key write request |
| key_wr_priv | input | 1 | Requester is privileged; the write only lands when high |
| key_wr_data | input | 20 | New key: [19:16] rotate amount, [15:0] XOR mask |
| in_valid | input | 1 | Fetch word present |
| in_word | input | 64 | Fetch word, four 16-bit parcels |
| in_page_enc | input | 1 | Fetch comes from a page marked scrambled |
| out_valid | output | 1 | Decoded word present |
| out_word | output | 64 | Decoded parcels |

## Verification
The bench aims at the rotate extremes 0 and 15. An off-by-one or a wrong rotate direction would corrupt every round trip there, and a 16-bit shift done wrong would zero a parcel at amount 0. It writes a key in the same cycle as a fetch, which a design that bypassed the key register forward would decode with the new key. An unprivileged write is followed by a scrambled fetch, and a design that ignored the privilege bit would decode that fetch with the rejected key. Plain-page fetches under a non-zero key and idle gaps catch a design that decrypts regardless of the page bit or lets out_word drift while nothing is valid.

// File: rtl/parcel_xor_pkg.sv
package parcel_xor_pkg;

  localparam int PARCEL_W = 16;
  localparam int ROT_W    = $clog2(PARCEL_W);

  // Key layout: rotate amount above the mask.
  typedef struct packed {
    logic [ROT_W-1:0]    rot;
    logic [PARCEL_W-1:0] mask;
  } pkey_t;

  localparam int KEY_W = $bits(pkey_t);

  typedef logic [PARCEL_W-1:0] parcel_t;

  // Right rotate through a doubled copy, so an amount of zero needs no special case.
  function automatic parcel_t rot_right(input parcel_t x, input logic [ROT_W-1:0] r);
    logic [2*PARCEL_W-1:0] dbl;
    dbl = {x, x} >> r;
    return dbl[PARCEL_W-1:0];
  endfunction

  function automatic parcel_t rot_left(input parcel_t x, input logic [ROT_W-1:0] r);
    logic [2*PARCEL_W-1:0] dbl;
    dbl = {x, x} << r;
    return dbl[2*PARCEL_W-1:PARCEL_W];
  endfunction

  // Unscramble: XOR first, then right rotate.
  function automatic parcel_t unscramble(input parcel_t p, input pkey_t k);
    return rot_right(p ^ k.mask, k.rot);
  endfunction

  // Scramble, the inverse: left rotate first, then XOR.
  function automatic parcel_t scramble(input parcel_t p, input pkey_t k);
    return rot_left(p, k.rot) ^ k.mask;
  endfunction

endpackage

// File: rtl/pxd_key_store.sv
module pxd_key_store
  import parcel_xor_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_priv,
  input  logic [KEY_W-1:0] wr_data,
  output pkey_t            key_q,
  output logic             wr_accept
);

  assign wr_accept = wr_en & wr_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (wr_accept) begin
      key_q <= pkey_t'(wr_data);
    end
  end

endmodule

// File: rtl/pxd_lane.sv
module pxd_lane
  import parcel_xor_pkg::*;
(
  input  parcel_t parcel_in,
  input  pkey_t   key,
  input  logic    page_enc,
  output parcel_t parcel_out
);

  parcel_t plain;

  always_comb begin
    plain      = unscramble(parcel_in, key);
    parcel_out = page_enc ? plain : parcel_in;
  end

endmodule

// File: rtl/parcel_decrypt_stage.sv
module parcel_decrypt_stage
  import parcel_xor_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_wr_en,
  input  logic                      key_wr_priv,
  input  logic [KEY_W-1:0]          key_wr_data,
  input  logic                      in_valid,
  input  logic [LANES*PARCEL_W-1:0] in_word,
  input  logic                      in_page_enc,
  output logic                      out_valid,
  output logic [LANES*PARCEL_W-1:0] out_word
);

  localparam int WORD_W = LANES * PARCEL_W;

  // Named internal events for the checker.
  pkey_t             key_now;
  logic              key_wr_accept;
  logic [WORD_W-1:0] dec_word;

  pxd_key_store u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (key_wr_en),
    .wr_priv   (key_wr_priv),
    .wr_data   (key_wr_data),
    .key_q     (key_now),
    .wr_accept (key_wr_accept)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pxd_lane u_lane (
      .parcel_in  (in_word[g*PARCEL_W +: PARCEL_W]),
      .key        (key_now),
      .page_enc   (in_page_enc),
      .parcel_out (dec_word[g*PARCEL_W +: PARCEL_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= dec_word;
      end
    end
  end

endmodule

// File: rtl/parcel_decrypt_stage_chk.sv
module parcel_decrypt_stage_chk
  import parcel_xor_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_wr_en,
  input logic              key_wr_priv,
  input logic [KEY_W-1:0]  key_wr_data,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              in_page_enc,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input pkey_t             key_now
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R5
  plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_page_enc) |=> (out_word == $past(in_word)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

  // R6
  priv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_en && key_wr_priv) |=> (key_now == pkey_t'($past(key_wr_data))));

  // R7
  unpriv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_en && !key_wr_priv) |=> $stable(key_now));

endmodule

bind parcel_decrypt_stage parcel_decrypt_stage_chk #(.WORD_W(WORD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .key_wr_en   (key_wr_en),
  .key_wr_priv (key_wr_priv),
  .key_wr_data (key_wr_data),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .in_page_enc (in_page_enc),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .key_now     (key_now)
);

// File: tb/parcel_decrypt_stage_tb_top.sv
module parcel_decrypt_stage_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_wr_en = 1'b0;
  logic        key_wr_priv = 1'b0;
  logic [19:0] key_wr_data = '0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic        in_page_enc = 1'b0;
  logic        out_valid;
  logic [63:0] out_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit started  = 0;
  bit done     = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [19:0] model_key = '0;
  logic [63:0] last_out  = '0;

  always #2 clk = ~clk;

  parcel_decrypt_stage dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr_en   (key_wr_en),
    .key_wr_priv (key_wr_priv),
    .key_wr_data (key_wr_data),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .in_page_enc (in_page_enc),
    .out_valid   (out_valid),
    .out_word    (out_word)
  );

  // Bit-level model: output bit j takes bit (j+r) mod 16 of the masked parcel.
  function automatic logic [15:0] m_dec(input logic [15:0] p, input logic [19:0] k);
    logic [15:0] m;
    logic [15:0] o;
    m = p ^ k[15:0];
    for (int j = 0; j < 16; j++) o[j] = m[(j + int'(k[19:16])) % 16];
    return o;
  endfunction

  function automatic logic [15:0] m_enc(input logic [15:0] p, input logic [19:0] k);
    logic [15:0] t;
    for (int j = 0; j < 16; j++) t[j] = p[(j + 16 - int'(k[19:16])) % 16];
    return t ^ k[15:0];
  endfunction

  function automatic logic [63:0] w_dec(input logic [63:0] w, input logic [19:0] k);
    logic [63:0] o;
    for (int i = 0; i < 4; i++) o[i*16 +: 16] = m_dec(w[i*16 +: 16], k);
    return o;
  endfunction

  function automatic logic [63:0] w_enc(input logic [63:0] w, input logic [19:0] k);
    logic [63:0] o;
    for (int i = 0; i < 4; i++) o[i*16 +: 16] = m_enc(w[i*16 +: 16], k);
    return o;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, pushing the expected result.
  task automatic drive(input logic v, input logic [63:0] w, input logic pe,
                       input logic we, input logic wp, input logic [19:0] wd,
                       input string tag);
    @(negedge clk);
    in_valid    = v;
    in_word     = w;
    in_page_enc = pe;
    key_wr_en   = we;
    key_wr_priv = wp;
    key_wr_data = wd;
    if (v) begin
      exp_q.push_back(pe ? w_dec(w, model_key) : w);
      tag_q.push_back(tag);
    end
    if (we && wp) model_key = wd;
  endtask

  task automatic fetch(input logic [63:0] w, input logic pe, input string tag);
    drive(1'b1, w, pe, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R8");
  endtask

  task automatic load_key(input logic [19:0] k);
    drive(1'b0, '0, 1'b0, 1'b1, 1'b1, k, "R6");
  endtask

  // Monitor: pops the scoreboard on each valid output, checks hold while idle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (started) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check("R2 unexpected out_valid", {63'd0, out_valid}, 64'd0);
          end else begin
            check(tag_q.pop_front(), out_word, exp_q.pop_front());
          end
          last_out = out_word;
        end else begin
          check("R8 hold", out_word, last_out);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] pt;
    repeat (4) @(negedge clk);
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 out_word", out_word, 64'd0);
    rst_n = 1'b1;
    started = 1;

    // R1: zero key leaves a marked page unchanged
    fetch(64'h0123_4567_89AB_CDEF, 1'b1, "R1 zero key");
    idle(2);

    // R6 then R3 with raw words and R4 with distinct parcels
    load_key({4'd5, 16'hA5C3});
    fetch(64'hFFFF_0000_1234_8001, 1'b1, "R3 raw decode");
    fetch(64'h0001_0002_0004_0008, 1'b1, "R4 independent parcels");
    pt = 64'hDEAD_BEEF_CAFE_F00D;
    fetch(w_enc(pt, model_key), 1'b1, "R4 round trip");
    // R2 back-to-back stream
    for (int i = 0; i < 6; i++)
      fetch({16'(i), 16'(i * 3), 16'(~i), 16'(i << 7)}, i[0], "R2 stream");
    idle(3);

    // R5: plain pages under non-zero key
    fetch(64'h5555_AAAA_0F0F_F0F0, 1'b0, "R5 plain");
    fetch(64'h0000_0000_0000_0000, 1'b0, "R5 plain zero");
    idle(1);

    // R7: unprivileged write is ignored
    drive(1'b0, '0, 1'b0, 1'b1, 1'b0, {4'd9, 16'h1111}, "R7");
    fetch(64'h1357_9BDF_2468_ACE0, 1'b1, "R7 key unchanged");
    idle(2);

    // R6: fetch in same cycle as write uses old key; next uses new
    drive(1'b1, 64'h8421_8421_8421_8421, 1'b1, 1'b1, 1'b1, {4'd11, 16'h3C3C}, "R6 old key");
    fetch(64'h8421_8421_8421_8421, 1'b1, "R6 new key");
    idle(2);

    // R9: rotate extremes, round trips
    load_key({4'd0, 16'h7E81});
    pt = 64'h0102_0304_0506_0708;
    fetch(w_enc(pt, model_key), 1'b1, "R9 rot 0");
    load_key({4'd15, 16'hC001});
    fetch(w_enc(pt, model_key), 1'b1, "R9 rot 15");
    fetch(64'h8000_0001_4000_0002, 1'b1, "R9 rot 15 raw");
    idle(4);

    check("R2 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule